// File: doc/BRIEF.md
# Vectored Interrupt Controller

This controller sits beside a small microcontroller core and turns single-cycle request pulses from eight peripheral sources into vectored calls. Each source has a pending latch that a pulse sets. Two enable registers, which software can write and read, mask the sources. A global enable flag in the processor gates all of them. The bench and the design call the registers "main" (select 0) and "endpoint" (select 1).

The core raises `instr_last` in the final clock cycle of each instruction. In that cycle the controller looks for a source that is both pending and enabled. If the global flag is also set, it services the source with the lowest vector number. Servicing takes one clock edge. On that edge the global flag drops, the latch of that source clears, and a one-cycle strobe appears together with the vector address. The address is twice the vector number. The EI and RETI pulses from the instruction decoder set the global flag again, so interrupts nest only when firmware allows it.

Source index to vector number: 0 USB bus reset → 1, 1 short-period timer → 2, 2 long-period timer → 3, 3/4/5 endpoints 0/1/2 → 4/5/6, 6 DAC → 10, 7 GPIO → 11. Vector 0 (address 0x0000) is the reset entry. Vectors 7 to 9 and 12 are unused.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high, both enable registers, every pending latch and the global flag clear, and `vec_req` is 0. After reset the global flag stays 0 until EI or RETI.
- R2: The main enable register (`wr_sel`=0) maps bit0 to source 0, bit1 to source 1, bit2 to source 2, bit4 to source 6 and bit5 to source 7. Bits 3, 6 and 7 ignore writes and read as 0, so writing 0xFF reads back 0x37.
- R3: The endpoint enable register (`wr_sel`=1) maps bits 0..2 to sources 3..5. Bits 3..7 ignore writes and read as 0, so writing 0xFF reads back 0x07.
- R4: A service starts only on a clock edge where `instr_last`=1, the global flag is 1 and some enabled source is pending. In any other case `vec_req` stays 0.
- R5: After a service edge, `vec_req` is 1 for exactly one cycle, `vec_addr` holds the vector address, and `gie` reads 0.
- R6: The vector addresses are 0x0002, 0x0004, 0x0006, 0x0008, 0x000A and 0x000C for sources 0..5, 0x0014 for source 6 and 0x0016 for source 7.
- R7: When several enabled sources are pending at once, the one with the lowest vector number is serviced first.
- R8: A service clears only the latch of the serviced source. The other latches stay pending and are serviced later.
- R9: A pending latch whose source is masked stays set. It is serviced after the source is unmasked.
- R10: An EI or RETI pulse sets the global flag on the next edge. While the flag is 0, no service occurs. If a service edge and an EI pulse fall in the same cycle, the flag ends at 0.
- R11: A request pulse in the same cycle as its own latch's service clear leaves the latch set, so the source is serviced a second time.
- R12: A request pulse on a latch that is already pending has no further effect, so two pulses before a service give one service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Request pulses, one per source index |
| wr_en | input | 1 | Enable register write strobe |
| wr_sel | input | 1 | Write target: 0 main, 1 endpoint |
| wr_data | input | DW | Write data |
| rd_sel | input | 1 | Read target: 0 main, 1 endpoint |
| rd_data | output | DW | Read data of the selected enable register |
| instr_last | input | 1 | Final cycle of the current instruction |
| ei_pulse | input | 1 | EI executed: set the global flag |
| reti_pulse | input | 1 | RETI executed: set the global flag |
| gie | output | 1 | Global interrupt enable flag |
| vec_req | output | 1 | One-cycle vector call strobe |
| vec_addr | output | AW | Vector ROM address, valid with vec_req |

## Verification
Two functions can fall in the same cycle. A source can raise a new request in the very cycle its latch is cleared by a service. An EI pulse can also arrive in the cycle of a service edge. The bench drives a request pulse for the serviced source at the same time as `instr_last`. It then re-enables and expects that source's vector a second time. It also drives EI together with `instr_last` and expects `gie` to read 0 after the strobe.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
  // Vector number of a source index: sources 0..5 sit at vectors 1..6,
  // sources 6..7 follow the reserved gap at vectors 10..11.
  function automatic int vec_num(input int idx);
    return (idx < 6) ? idx + 1 : idx + 4;
  endfunction

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_EP   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_vc_enables.sv
module irq_vc_enables
  import irq_vc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int NSRC      = 8,
  parameter logic [DW-1:0] MAIN_MASK = 8'h37,
  parameter logic [DW-1:0] EP_MASK   = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [NSRC-1:0] en_o
);
  logic [DW-1:0] main_q, ep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      ep_q   <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == SEL_MAIN) main_q <= wr_data & MAIN_MASK;
      else                                ep_q   <= wr_data & EP_MASK;
    end
  end

  assign rd_data = (reg_sel_e'(rd_sel) == SEL_MAIN) ? main_q : ep_q;

  assign en_o = {main_q[5], main_q[4], ep_q[2], ep_q[1], ep_q[0],
                 main_q[2], main_q[1], main_q[0]};
endmodule

// File: rtl/irq_vc_pending.sv
module irq_vc_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst)           pend_o[i] <= 1'b0;
      else if (req_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vc_arbiter.sv
module irq_vc_arbiter
  import irq_vc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 16
) (
  input  logic [NSRC-1:0] cand_i,
  output logic            any_o,
  output logic [NSRC-1:0] grant_o,
  output logic [AW-1:0]   addr_o
);
  logic [NSRC:0] lower;

  assign lower[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_pick
    assign grant_o[i]  = cand_i[i] & ~lower[i];
    assign lower[i+1]  = lower[i] | cand_i[i];
  end
  assign any_o = lower[NSRC];

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) addr_o = addr_o | AW'(2 * vec_num(i));
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC = 8,
  parameter int DW   = 8,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_sel,
  output logic [DW-1:0]   rd_data,
  input  logic            instr_last,
  input  logic            ei_pulse,
  input  logic            reti_pulse,
  output logic            gie,
  output logic            vec_req,
  output logic [AW-1:0]   vec_addr
);
  logic [NSRC-1:0] en, pend, grant, clr;
  logic [AW-1:0]   pick_addr;
  logic            any, take;

  irq_vc_enables #(.DW(DW), .NSRC(NSRC)) u_en (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .en_o(en)
  );

  irq_vc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  irq_vc_arbiter #(.NSRC(NSRC), .AW(AW)) u_arb (
    .cand_i(pend & en), .any_o(any), .grant_o(grant), .addr_o(pick_addr)
  );

  assign take = instr_last & gie & any;
  assign clr  = take ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie      <= 1'b0;
      vec_req  <= 1'b0;
      vec_addr <= '0;
    end else begin
      vec_req <= take;
      if (take) begin
        gie      <= 1'b0;
        vec_addr <= pick_addr;
      end else if (ei_pulse || reti_pulse) begin
        gie <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vc_checker.sv
module irq_vc_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          instr_last,
  input logic          ei_pulse,
  input logic          reti_pulse,
  input logic          gie,
  input logic          vec_req,
  input logic [AW-1:0] vec_addr
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req); // R5
  AST_GIE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> !gie); // R5
  AST_ACK_CONDITION: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> ($past(instr_last) && $past(gie))); // R4
  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (vec_addr inside {16'h2, 16'h4, 16'h6, 16'h8, 16'hA, 16'hC, 16'h14, 16'h16})); // R6
  AST_GIE_REARM: assert property (@(posedge clk) disable iff (rst)
    (ei_pulse || reti_pulse) |=> (gie || vec_req)); // R10
endmodule

bind irq_vector_ctrl irq_vc_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .instr_last(instr_last), .ei_pulse(ei_pulse),
  .reti_pulse(reti_pulse), .gie(gie), .vec_req(vec_req), .vec_addr(vec_addr)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_i = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        instr_last = 1'b0, ei_pulse = 1'b0, reti_pulse = 1'b0;
  logic        gie, vec_req;
  logic [15:0] vec_addr;
  int errors = 0, checks = 0;
  logic [15:0] tbl [8] = '{16'h2, 16'h4, 16'h6, 16'h8, 16'hA, 16'hC, 16'h14, 16'h16};

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .instr_last(instr_last), .ei_pulse(ei_pulse), .reti_pulse(reti_pulse),
    .gie(gie), .vec_req(vec_req), .vec_addr(vec_addr)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic pulse(input logic [7:0] m);
    req_i = m; cyc(); req_i = '0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic sel, input int exp, input string tag);
    rd_sel = sel; #1;
    check(rd_data == exp[7:0], tag, rd_data, exp);
  endtask

  task automatic ei(); ei_pulse = 1'b1; cyc(); ei_pulse = 1'b0; endtask

  task automatic service(input logic [15:0] exp, input string tag);
    instr_last = 1'b1; cyc(); instr_last = 1'b0;
    check(vec_req == 1'b1, {tag, " strobe"}, vec_req, 1);
    check(vec_addr == exp, {tag, " addr"}, vec_addr, exp);
    check(gie == 1'b0, {tag, " R5 gie"}, gie, 0);
    cyc();
    check(vec_req == 1'b0, {tag, " R5 single"}, vec_req, 0);
  endtask

  task automatic no_service(input string tag);
    instr_last = 1'b1; cyc(); instr_last = 1'b0;
    check(vec_req == 1'b0, tag, vec_req, 0);
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    rst = 1'b0; cyc();
    check(gie == 1'b0, "R1 gie", gie, 0);
    check(vec_req == 1'b0, "R1 vec_req", vec_req, 0);
    rd_check(1'b0, 0, "R1 main");
    rd_check(1'b1, 0, "R1 ep");
    no_service("R1 gie low blocks");
  endtask

  task automatic t_regs();
    wr(1'b0, 8'hFF); rd_check(1'b0, 8'h37, "R2 main mask");
    wr(1'b1, 8'hFF); rd_check(1'b1, 8'h07, "R3 ep mask");
    ei(); no_service("R1 latches empty");
    ei();
  endtask

  task automatic t_table();
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i)); ei();
      service(tbl[i], "R6 table");
    end
  endtask

  task automatic t_priority();
    pulse(8'hFF);
    for (int k = 0; k < 8; k++) begin
      ei(); service(tbl[k], "R7 R8 order");
    end
    ei(); no_service("R8 all drained");
  endtask

  task automatic t_dup();
    pulse(8'h08); cyc(); pulse(8'h08);
    ei(); service(16'h8, "R12 first");
    ei(); no_service("R12 no second");
  endtask

  task automatic t_gating();
    ei(); pulse(8'h02);
    repeat (2) begin
      cyc(); check(vec_req == 1'b0, "R4 no instr_last", vec_req, 0);
    end
    service(16'h4, "R4 serviced");
    pulse(8'h02);
    no_service("R10 gie low");
    reti_pulse = 1'b1; cyc(); reti_pulse = 1'b0;
    check(gie == 1'b1, "R10 reti sets", gie, 1);
    service(16'h4, "R10 after reti");
  endtask

  task automatic t_mask();
    wr(1'b0, 8'h00); pulse(8'h80); ei();
    no_service("R9 masked");
    check(gie == 1'b1, "R9 gie kept", gie, 1);
    wr(1'b0, 8'h20);
    service(16'h16, "R9 unmasked");
    wr(1'b0, 8'h37);
  endtask

  task automatic t_collide();
    pulse(8'h04); ei();
    instr_last = 1'b1; req_i = 8'h04; cyc(); instr_last = 1'b0; req_i = '0;
    check(vec_req == 1'b1 && vec_addr == 16'h6, "R11 first", vec_addr, 6);
    ei(); service(16'h6, "R11 latch kept");
    ei(); no_service("R11 drained");
    pulse(8'h01);
    instr_last = 1'b1; ei_pulse = 1'b1; cyc(); instr_last = 1'b0; ei_pulse = 1'b0;
    check(vec_req == 1'b1 && vec_addr == 16'h2, "R10 collide strobe", vec_addr, 2);
    check(gie == 1'b0, "R10 ack beats ei", gie, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc();
    t_reset();
    t_regs();
    t_table();
    t_priority();
    t_dup();
    t_gating();
    t_mask();
    t_collide();
    cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule